// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Controller

This block is the digital control core of a two-channel, double-buffered DAC. A host writes it over a three-wire serial link: an active-low select, a data line and a serial clock. Each frame carries a two-bit channel selector and then a data word. When the select line is released, the frame loads the input register of channel A, of channel B, of both or of neither. A separate active-low, level-sensitive load input copies the input registers into the two DAC registers. Those DAC registers drive the converter and are the block's outputs.

The serial pins, the load input and the preset pin come from outside the chip. Each is brought into the system clock domain through a two-flop synchroniser. Serial-clock and select edges are then detected in that domain, so the system clock must run several times faster than the serial clock. A preset pin, and the system reset at power-on, force all four registers to zero or to midscale. A static strap input chooses which. If the load input is tied low the path becomes single-buffered, and each completed frame reaches the outputs directly.

Top module: `dual_dac_ctrl`

## Requirements
- R1: A frame is FRAME_W = DATA_W+2 bits, sampled on rising edges of `ser_clk` while `ser_cs_n` is low. The first bit is the B-select bit, the second is the A-select bit, and the data word follows most significant bit first. The frame takes effect on the rising edge of `ser_cs_n`.
- R2: While `ser_cs_n` is high, `ser_clk` edges shift nothing and load no register.
- R3: When more than FRAME_W bits are clocked in, only the last FRAME_W bits are used and the earlier ones are discarded.
- R4: Selector decode (B-bit, A-bit): 00 loads no channel, 01 loads channel A, 10 loads channel B, and 11 loads the same word into both.
- R5: A frame with fewer than FRAME_W bits since `ser_cs_n` fell is dropped, and no register changes.
- R6: While `load_n` is low, each DAC register takes the value of its input register one system cycle later. While `load_n` is high, the DAC registers hold.
- R7: While `preset_n` is low, both input registers and both DAC registers are forced to 0 when `mid_sel` is 0, and to midscale (only bit DATA_W-1 set, 0x8000 for 16 bits) when `mid_sel` is 1.
- R8: While `rst_n` is low (power-on), all four registers take the same zero or midscale value chosen by `mid_sel`.
- R9: A preset takes priority over a frame commit and over the load input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset (power-on preset) |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_cs_n | input | 1 | Active-low frame select; its rising edge commits the frame |
| ser_din | input | 1 | Serial data, most significant bit first |
| load_n | input | 1 | Active-low level-sensitive copy of input registers into DAC registers |
| preset_n | input | 1 | Active-low preset of all registers |
| mid_sel | input | 1 | Static strap: 0 presets to zero, 1 presets to midscale |
| dac_a | output | DATA_W | Channel A DAC register |
| dac_b | output | DATA_W | Channel B DAC register |

## Verification
Every pin passes two synchroniser flops before any logic sees it. A select-line release therefore loads an input register on the third system clock edge after the pin changes. With `load_n` low, the DAC output follows on the fourth edge. A change on `load_n` or `preset_n` reaches the outputs on the third edge. The bench drives pins on falling clock edges and samples outputs on falling edges. It waits at least six cycles after each stimulus before it checks, so every result is settled when sampled. For the priority case, the preset pulse and the select release are driven in the same cycle, so both arrive together.

// File: rtl/dac_ctrl_pkg.sv
// Shared types for the dual-channel DAC register controller.
package dac_ctrl_pkg;
    localparam int SEL_W = 2;
    // Channel selector as it appears in the frame: {B-bit, A-bit}.
    typedef enum logic [SEL_W-1:0] {
        SEL_NONE = 2'b00,
        SEL_A    = 2'b01,
        SEL_B    = 2'b10,
        SEL_BOTH = 2'b11
    } chan_sel_e;
endpackage

// File: rtl/pin_sync.sv
// Two-flop synchroniser for a bundle of independent asynchronous pins.
// Assumes each bit is quasi-static relative to clk; no bus coherency.
module pin_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two register stages; reset to the idle level of each pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/frame_shifter.sv
// Collects serial bits into a frame register and flags a complete frame.
// Inputs are already synchronised. Assumes the serial clock high and low
// phases each last at least two system clock cycles.
module frame_shifter #(
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sclk_s,
    input  logic                          cs_n_s,
    input  logic                          din_s,
    output logic                          commit,
    output logic [dac_ctrl_pkg::SEL_W-1:0] sel,
    output logic [DATA_W-1:0]             word
);
    localparam int FRAME_W = DATA_W + dac_ctrl_pkg::SEL_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    logic               sclk_d, cs_d;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;
    logic               sclk_rise, cs_rise;

    // Edge detection on the synchronised serial clock and select.
    always_comb begin
        sclk_rise = sclk_s & ~sclk_d;
        cs_rise   = cs_n_s & ~cs_d;
    end

    // Shift on serial clock rises within a frame; count bits, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
            shreg  <= '0;
            cnt    <= '0;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_n_s;
            if (cs_n_s) begin
                cnt <= '0;
            end else if (sclk_rise) begin
                shreg <= {shreg[FRAME_W-2:0], din_s};
                if (cnt != CNT_FULL) cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // A frame counts only if it held at least FRAME_W bits.
    always_comb begin
        commit = cs_rise && (cnt == CNT_FULL);
        sel    = shreg[FRAME_W-1 -: dac_ctrl_pkg::SEL_W];
        word   = shreg[DATA_W-1:0];
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_FULL); // R5
    AST_SHIFT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> $stable(shreg)); // R2
    AST_SHORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && cnt != CNT_FULL) |-> !commit); // R5
endmodule

// File: rtl/chan_regs.sv
// One channel: input register written by a frame commit, and a DAC register
// that copies it while the load strobe is active. Preset wins over both.
module chan_regs #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preset_act,
    input  logic [DATA_W-1:0] preset_val,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_act,
    output logic [DATA_W-1:0] dac_q
);
    logic [DATA_W-1:0] in_q;

    // Input register: preset first, then frame write.
    always_ff @(posedge clk) begin
        if (!rst_n || preset_act) in_q <= preset_val;
        else if (wr_en)           in_q <= wr_data;
    end

    // DAC register: preset first, then transparent copy while loading.
    always_ff @(posedge clk) begin
        if (!rst_n || preset_act) dac_q <= preset_val;
        else if (load_act)        dac_q <= in_q;
    end

    AST_PRESET_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        preset_act |=> (dac_q == $past(preset_val))); // R7
    AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_act && !load_act) |=> $stable(dac_q)); // R6
    AST_LOAD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_act && load_act) |=> (dac_q == $past(in_q))); // R6
    AST_PRESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_act && wr_en) |=> (in_q == $past(preset_val))); // R9
endmodule

// File: rtl/dual_dac_ctrl.sv
// Top of the dual-channel serial DAC register controller. Synchronises the
// pins, assembles frames, decodes the channel selector and drives both
// channel register pairs. Assumes mid_sel is a static strap.
module dual_dac_ctrl #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_cs_n,
    input  logic              ser_din,
    input  logic              load_n,
    input  logic              preset_n,
    input  logic              mid_sel,
    output logic [DATA_W-1:0] dac_a,
    output logic [DATA_W-1:0] dac_b
);
    import dac_ctrl_pkg::*;

    localparam int NCH   = 2;
    localparam int SYNC_W = 5;
    localparam logic [DATA_W-1:0] MID_VAL = DATA_W'(1) << (DATA_W - 1);
    // Idle levels: {ser_clk, ser_cs_n, ser_din, load_n, preset_n}
    localparam logic [SYNC_W-1:0] SYNC_IDLE = 5'b01011;

    logic [SYNC_W-1:0] pins_s;
    logic              sclk_s, cs_n_s, din_s, load_n_s, preset_n_s;
    logic              commit;
    logic [SEL_W-1:0]  sel_raw;
    chan_sel_e         sel;
    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] preset_val;
    logic [NCH-1:0]    wr_en;
    logic [DATA_W-1:0] dac_word [NCH];

    pin_sync #(.W(SYNC_W), .RST_VAL(SYNC_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_clk, ser_cs_n, ser_din, load_n, preset_n}),
        .q     (pins_s)
    );

    // Unpack the synchronised pin bundle.
    always_comb {sclk_s, cs_n_s, din_s, load_n_s, preset_n_s} = pins_s;

    frame_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (sclk_s),
        .cs_n_s (cs_n_s),
        .din_s  (din_s),
        .commit (commit),
        .sel    (sel_raw),
        .word   (word)
    );

    // Selector decode into per-channel write enables (ch0 = A, ch1 = B).
    always_comb begin
        sel        = chan_sel_e'(sel_raw);
        preset_val = mid_sel ? MID_VAL : '0;
        wr_en[0]   = commit && (sel == SEL_A || sel == SEL_BOTH);
        wr_en[1]   = commit && (sel == SEL_B || sel == SEL_BOTH);
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        chan_regs #(.DATA_W(DATA_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .preset_act (!preset_n_s),
            .preset_val (preset_val),
            .wr_en      (wr_en[ch]),
            .wr_data    (word),
            .load_act   (!load_n_s),
            .dac_q      (dac_word[ch])
        );
    end

    assign dac_a = dac_word[0];
    assign dac_b = dac_word[1];

    AST_NONE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && sel == SEL_NONE) |-> (wr_en == '0)); // R4
endmodule

// File: tb/dual_dac_ctrl_tb.sv
module dual_dac_ctrl_tb;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_cs_n = 1'b1, ser_din = 1'b0;
    logic load_n = 1'b1, preset_n = 1'b1, mid_sel = 1'b0;
    logic [DW-1:0] dac_a, dac_b;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dual_dac_ctrl #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_cs_n(ser_cs_n),
        .ser_din(ser_din), .load_n(load_n), .preset_n(preset_n),
        .mid_sel(mid_sel), .dac_a(dac_a), .dac_b(dac_b)
    );

    // {sel[1:0], data, expected A, expected B}; load pulsed after each.
    localparam logic [49:0] VEC [6] = '{
        {2'b01, 16'h1234, 16'h1234, 16'h0000},
        {2'b10, 16'hABCD, 16'h1234, 16'hABCD},
        {2'b11, 16'h5A5A, 16'h5A5A, 16'h5A5A},
        {2'b00, 16'hFFFF, 16'h5A5A, 16'h5A5A},
        {2'b01, 16'hFFFF, 16'hFFFF, 16'h5A5A},
        {2'b10, 16'h0001, 16'hFFFF, 16'h0001}
    };

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [DW-1:0] got,
                         input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Send nbits of bits (MSB first). With clash set, preset_n pulses low
    // for one cycle together with the select release.
    task automatic send_frame(input int nbits, input logic [31:0] bits,
                              input bit clash);
        ser_cs_n = 1'b0;
        wait_n(4);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_din = bits[i];
            wait_n(3);
            ser_clk = 1'b1;
            wait_n(3);
            ser_clk = 1'b0;
        end
        wait_n(3);
        ser_cs_n = 1'b1;
        if (clash) begin
            preset_n = 1'b0;
            wait_n(1);
            preset_n = 1'b1;
        end
        wait_n(8);
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        wait_n(6);
        load_n = 1'b1;
        wait_n(6);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(6);
    endtask

    initial begin
        wait_n(2);
        // R8: power-on to zero
        do_reset();
        check("R8 reset zero A", dac_a, 16'h0000);
        check("R8 reset zero B", dac_b, 16'h0000);

        // R1 R4 R6: table of frames followed by a load pulse
        for (int v = 0; v < 6; v++) begin
            send_frame(18, {14'd0, VEC[v][49:32]}, 1'b0);
            pulse_load();
            check("R4 table A", dac_a, VEC[v][31:16]);
            check("R4 table B", dac_b, VEC[v][15:0]);
        end

        // R6: double buffering holds the output until load
        send_frame(18, {14'd0, 2'b01, 16'h4321}, 1'b0);
        check("R6 hold while load high", dac_a, 16'hFFFF);
        pulse_load();
        check("R6 copy on load", dac_a, 16'h4321);

        // R6: load tied low makes the path single-buffered
        load_n = 1'b0;
        wait_n(6);
        send_frame(18, {14'd0, 2'b10, 16'h7777}, 1'b0);
        check("R6 transparent B", dac_b, 16'h7777);
        load_n = 1'b1;
        wait_n(6);

        // R2: serial clocks with select high change nothing
        ser_din = 1'b1;
        for (int k = 0; k < 20; k++) begin
            ser_clk = 1'b1; wait_n(3);
            ser_clk = 1'b0; wait_n(3);
        end
        ser_din = 1'b0;
        pulse_load();
        check("R2 idle clocks A", dac_a, 16'h4321);
        check("R2 idle clocks B", dac_b, 16'h7777);

        // R3: six leading pad bits are discarded
        send_frame(24, {8'd0, 6'b111111, 2'b01, 16'hC3C3}, 1'b0);
        pulse_load();
        check("R3 padded frame A", dac_a, 16'hC3C3);
        check("R3 padded frame B", dac_b, 16'h7777);

        // R5: a 17-bit frame is dropped
        send_frame(17, {15'd0, 1'b1, 16'h0F0F}, 1'b0);
        pulse_load();
        check("R5 short frame A", dac_a, 16'hC3C3);
        check("R5 short frame B", dac_b, 16'h7777);

        // R7: preset to midscale, then to zero
        mid_sel = 1'b1;
        preset_n = 1'b0;
        wait_n(6);
        preset_n = 1'b1;
        wait_n(4);
        check("R7 preset mid A", dac_a, 16'h8000);
        check("R7 preset mid B", dac_b, 16'h8000);
        pulse_load();
        check("R7 input reg preset mid", dac_a, 16'h8000);
        mid_sel = 1'b0;
        preset_n = 1'b0;
        wait_n(6);
        preset_n = 1'b1;
        wait_n(4);
        check("R7 preset zero A", dac_a, 16'h0000);

        // R9: preset in the same cycle as a commit wins
        mid_sel = 1'b1;
        send_frame(18, {14'd0, 2'b11, 16'h1111}, 1'b1);
        check("R9 clash dac A", dac_a, 16'h8000);
        pulse_load();
        check("R9 clash input A", dac_a, 16'h8000);
        check("R9 clash input B", dac_b, 16'h8000);

        // R9: preset overrides an active load
        send_frame(18, {14'd0, 2'b01, 16'h2222}, 1'b0);
        load_n = 1'b0;
        preset_n = 1'b0;
        wait_n(6);
        check("R9 preset over load", dac_a, 16'h8000);
        preset_n = 1'b1;
        load_n = 1'b1;
        wait_n(6);

        // R8: power-on to midscale
        do_reset();
        check("R8 reset mid A", dac_a, 16'h8000);
        check("R8 reset mid B", dac_b, 16'h8000);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog got=timeout exp=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule